// File: doc/BRIEF.md
# Buffered 16-bit Tick Counter

This block is a byte-addressed timer/counter. It advances either once per instruction cycle, taken here as one `clk` period, or on a chosen edge of an asynchronous count pin. The pin is first brought into the clock domain by a synchronizer. A divide-by-2^(n+1) prescaler can sit in the count path or be bypassed. The counter is either an 8-bit or a 16-bit counter. A sticky flag output goes high whenever the counter rolls over.

Software sees four byte registers: control, counter low byte, high-byte buffer and overflow flag. In 16-bit mode the live high byte cannot be reached directly. A read of the low byte takes a snapshot of the high byte into the buffer, so the two halves always come from the same instant. A write of the low byte commits the buffer into the high byte, so all 16 bits change together. Any write to the counter holds off counting for two cycles and restarts the prescaler.

Top module: `tick_counter_unit`

## Requirements
- R1: After reset the control register reads 0xA7 (run=1, 8-bit, pin source, rising edge, prescaler in use, ratio 7), and the low byte, the buffer and the flag all read 0.
- R2: The control fields are bit7 run, bit6 wide (1 = 16-bit), bit5 source (1 = pin, 0 = every clock cycle), bit4 falling edge, bit3 bypass, and bits 2:0 ratio. With source 0 and bypass 1 the counter advances by one on every clock.
- R3: With source 1 the counter counts rising pin edges when bit4 is 0 and falling edges when bit4 is 1. A pin level first sampled at edge k is counted at edge k+2.
- R4: With bypass 0 and ratio n, the counter advances once per 2^(n+1) qualified ticks, counted from the last counter write. In bypass mode the prescaler holds its state.
- R5: A write to register 1 (the low byte) loads the counter and clears the prescaler. Ticks at the next two clock edges are dropped and do not advance the prescaler.
- R6: In 16-bit mode, a read of register 1 copies the live high byte into the buffer (register 2) at that clock edge. A buffer write in the same cycle takes precedence.
- R7: A write to register 2 loads only the buffer and leaves the counter unchanged. In 16-bit mode, a low-byte write also loads the high byte from the buffer.
- R8: In 8-bit mode only the low byte counts and it wraps from 0xFF to 0x00. The high byte keeps its value, a low-byte read does not update the buffer, and a low-byte write does not commit the buffer.
- R9: A rollover (0xFF to 0x00 in 8-bit mode, 0xFFFF to 0x0000 in 16-bit mode) sets the overflow flag, which then stays set.
- R10: The flag (register 3, bit 0) clears when software writes a 0 to bit 0 in a cycle with no new rollover. Writing a 1 to bit 0 has no effect.
- R11: With run = 0 the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 1 | External count pin, asynchronous |
| bus_sel | input | 2 | Register select: 0 control, 1 low byte, 2 high buffer, 3 flag |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (snapshots the high byte on a low-byte read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench targets the two-cycle hold-off after a counter write: a design that counted one cycle early or late would read back off by one. It checks that a buffer write leaves the live high byte alone, which catches a design that writes the high byte straight through. It checks that an 8-bit wrap leaves the high byte unchanged, which catches a design that carries into it. It also checks that a flag write of 1 leaves the flag set and that the prescaler period matches the ratio code, where a wrong code would give a count too large or too small by a power of two.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HBUF = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       run;
    logic       wide;
    logic       src_pin;
    logic       fall_edge;
    logic       bypass;
    logic [2:0] ratio;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{run: 1'b1, wide: 1'b0, src_pin: 1'b1,
                                 fall_edge: 1'b0, bypass: 1'b0, ratio: 3'b111};

  // Prescaler reaches its terminal tick when the low ratio+1 bits are all ones.
  function automatic logic pre_terminal(input logic [BYTE_W-1:0] cnt,
                                        input logic [2:0] ratio);
    logic [BYTE_W-1:0] mask;
    mask = BYTE_W'((9'd2 << ratio) - 9'd1);
    return (cnt & mask) == mask;
  endfunction

  // Increment with carry-out for the full-width counter.
  function automatic logic [CNT_W:0] inc_wide(input logic [CNT_W-1:0] v);
    return {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  // Increment with carry-out for the low byte only.
  function automatic logic [BYTE_W:0] inc_byte(input logic [BYTE_W-1:0] v);
    return {1'b0, v} + {{BYTE_W{1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/tcu_pin_sync.sv
module tcu_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_rise,
  output logic pin_fall
);

  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg[0] <= 1'b0;
    else        shreg[0] <= pin_async;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg[i] <= 1'b0;
      else        shreg[i] <= shreg[i-1];
    end
  end

  assign pin_rise = shreg[STAGES-1] & ~shreg[STAGES];
  assign pin_fall = ~shreg[STAGES-1] & shreg[STAGES];

  // R3: a synchronized level cannot rise on two consecutive cycles
  assert_rise_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);
  assert_fall_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |=> !pin_fall);

endmodule

// File: rtl/tcu_prescale.sv
module tcu_prescale
  import tcu_pkg::*;
#(
  parameter int INHIBIT_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       load,
  input  logic       bypass,
  input  logic [2:0] ratio,
  output logic       adv
);

  localparam int INH_W = $clog2(INHIBIT_CYC + 1);

  logic [INH_W-1:0]  inh_cnt;
  logic [BYTE_W-1:0] pre_cnt;
  logic              inh_busy;
  logic              gated_tick;

  assign inh_busy   = (inh_cnt != '0);
  assign gated_tick = tick_in & ~inh_busy;
  assign adv        = gated_tick & (bypass | pre_terminal(pre_cnt, ratio));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        inh_cnt <= '0;
    else if (load)     inh_cnt <= INH_W'(INHIBIT_CYC);
    else if (inh_busy) inh_cnt <= inh_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pre_cnt <= '0;
    else if (load)                   pre_cnt <= '0;
    else if (gated_tick && !bypass)  pre_cnt <= adv ? '0 : pre_cnt + 1'b1;
  end

  // R5: no advance in the cycle right after a counter write
  assert_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !adv);

  if (INHIBIT_CYC >= 2) begin : g_inh2
    // R5: nor in the second cycle
    assert_inhibit2_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load, 2) |-> !adv);
  end

  // R4: a prescaled advance is never followed at once by another one
  assert_prescale_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !bypass) |=> (!adv || bypass));

endmodule

// File: rtl/tcu_count_regs.sv
module tcu_count_regs
  import tcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              adv,
  input  logic              load,
  input  logic              wr_hbuf,
  input  logic              rd_low,
  input  logic              flag_clr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] hbuf,
  output logic              ovf,
  output logic              roll
);

  logic [CNT_W:0]  next_wide;
  logic [BYTE_W:0] next_byte;
  logic            step;

  assign next_wide = inc_wide(cnt);
  assign next_byte = inc_byte(cnt[BYTE_W-1:0]);
  assign step      = adv & ~load;
  assign roll      = step & (wide ? next_wide[CNT_W] : next_byte[BYTE_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt[BYTE_W-1:0] <= wdata;
      if (wide) cnt[CNT_W-1:BYTE_W] <= hbuf;
    end else if (step) begin
      if (wide) cnt <= next_wide[CNT_W-1:0];
      else      cnt[BYTE_W-1:0] <= next_byte[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hbuf <= '0;
    else if (wr_hbuf)         hbuf <= wdata;
    else if (rd_low && wide)  hbuf <= cnt[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf <= 1'b0;
    else if (roll)     ovf <= 1'b1;
    else if (flag_clr) ovf <= 1'b0;
  end

  // R2: 8-bit step adds exactly one to the low byte
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !wide) |=> cnt[BYTE_W-1:0] == $past(cnt[BYTE_W-1:0]) + 1'b1);
  // R6: a low-byte read snapshots the live high byte
  assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_low && wide && !wr_hbuf) |=> hbuf == $past(cnt[CNT_W-1:BYTE_W]));
  // R7: a low-byte write in 16-bit mode commits the buffer
  assert_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && wide) |=> cnt[CNT_W-1:BYTE_W] == $past(hbuf));
  // R7: a buffer write alone leaves the counter untouched
  assert_hbuf_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hbuf && !load && !adv) |=> $stable(cnt));
  // R8: the high byte is frozen in 8-bit mode
  assert_high_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !load) |=> cnt[CNT_W-1:BYTE_W] == $past(cnt[CNT_W-1:BYTE_W]));
  // R9: rollover raises the flag
  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> ovf);
  // R9: the flag stays up until a clear request
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flag_clr) |=> ovf);

endmodule

// File: rtl/tick_counter_unit.sv
module tick_counter_unit
  import tcu_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_async,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              ovf_flag
);

  ctrl_t             ctrl;
  reg_sel_e          sel;
  logic              pin_rise, pin_fall;
  logic              src_tick, tick_q, adv, roll;
  logic              wr_ctrl, load, wr_hbuf, rd_low, flag_clr;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] hbuf;

  assign sel      = reg_sel_e'(bus_sel);
  assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
  assign load     = bus_wr && (sel == SEL_LOW);
  assign wr_hbuf  = bus_wr && (sel == SEL_HBUF);
  assign flag_clr = bus_wr && (sel == SEL_FLAG) && !bus_wdata[0];
  assign rd_low   = bus_rd && (sel == SEL_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= CTRL_RST;
    else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata);
  end

  tcu_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_async),
    .pin_rise  (pin_rise),
    .pin_fall  (pin_fall)
  );

  assign src_tick = ctrl.src_pin ? (ctrl.fall_edge ? pin_fall : pin_rise) : 1'b1;
  assign tick_q   = ctrl.run & src_tick;

  tcu_prescale #(.INHIBIT_CYC(INHIBIT_CYC)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_q),
    .load    (load),
    .bypass  (ctrl.bypass),
    .ratio   (ctrl.ratio),
    .adv     (adv)
  );

  tcu_count_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (ctrl.wide),
    .adv      (adv),
    .load     (load),
    .wr_hbuf  (wr_hbuf),
    .rd_low   (rd_low),
    .flag_clr (flag_clr),
    .wdata    (bus_wdata),
    .cnt      (cnt),
    .hbuf     (hbuf),
    .ovf      (ovf_flag),
    .roll     (roll)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: bus_rdata = ctrl;
      SEL_LOW:  bus_rdata = cnt[BYTE_W-1:0];
      SEL_HBUF: bus_rdata = hbuf;
      SEL_FLAG: bus_rdata = {{(BYTE_W-1){1'b0}}, ovf_flag};
      default:  bus_rdata = '0;
    endcase
  end

  // R1: control comes out of reset with its defined value
  assert_ctrl_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> ctrl == CTRL_RST);
  // R10: an accepted clear request drops the flag
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !roll) |=> !ovf_flag);
  // R11: a stopped counter holds its value
  assert_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !load) |=> $stable(cnt));

endmodule

// File: tb/tick_counter_unit_bench.sv
module tick_counter_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rdata;
  logic       ovf_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_counter_unit u_tick_counter_unit (
    .clk (clk), .rst_n (rst_n), .pin_async (pin),
    .bus_sel (sel), .bus_wr (wr), .bus_rd (rd),
    .bus_wdata (wd), .bus_rdata (rdata), .ovf_flag (ovf_flag)
  );

  // Reference state, derived from the requirements
  logic [7:0]  m_ctrl;
  logic [15:0] m_cnt;
  logic [7:0]  m_hb;
  logic        m_ovf;
  int          m_pre;
  int          m_inh;
  logic [2:0]  m_pin;

  always @(posedge clk) begin : model
    logic rise_e, fall_e, ld, src_ok, tk, stepc, roll, wide;
    logic [15:0] ocnt;
    int period;
    if (!rst_n) begin
      m_ctrl = 8'hA7; m_cnt = '0; m_hb = '0; m_ovf = 1'b0;
      m_pre = 0; m_inh = 0; m_pin = '0;
    end else begin
      rise_e = m_pin[1] & ~m_pin[2];
      fall_e = ~m_pin[1] & m_pin[2];
      ld     = wr && sel == 2'd1;
      src_ok = m_ctrl[5] ? (m_ctrl[4] ? fall_e : rise_e) : 1'b1;
      tk     = m_ctrl[7] && src_ok && m_inh == 0;
      wide   = m_ctrl[6];
      period = 2 << m_ctrl[2:0];
      stepc  = 1'b0;
      if (tk) stepc = m_ctrl[3] ? 1'b1 : (((m_pre + 1) % period) == 0);
      if (ld) m_pre = 0;
      else if (tk && !m_ctrl[3]) m_pre = stepc ? 0 : m_pre + 1;
      if (ld) m_inh = 2; else if (m_inh > 0) m_inh = m_inh - 1;
      ocnt = m_cnt;
      roll = 1'b0;
      if (ld) begin
        m_cnt[7:0] = wd;
        if (wide) m_cnt[15:8] = m_hb;
      end else if (stepc) begin
        if (wide) begin roll = (ocnt == 16'hFFFF); m_cnt = ocnt + 16'd1; end
        else begin roll = (ocnt[7:0] == 8'hFF); m_cnt[7:0] = ocnt[7:0] + 8'd1; end
      end
      if (wr && sel == 2'd2) m_hb = wd;
      else if (rd && sel == 2'd1 && wide) m_hb = ocnt[15:8];
      if (roll) m_ovf = 1'b1;
      else if (wr && sel == 2'd3 && !wd[0]) m_ovf = 1'b0;
      if (wr && sel == 2'd0) m_ctrl = wd;
      m_pin = {m_pin[1:0], pin};
    end
  end

  function automatic logic [7:0] expect_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_cnt[7:0];
      2'd2: return m_hb;
      default: return {7'd0, m_ovf};
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    sel = a; wd = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // Reads compare against the model; hand value is checked too when given
  task automatic bus_read(input logic [1:0] a, input string tag,
                          input bit use_hand, input logic [7:0] hand);
    sel = a; rd = 1'b1;
    #1;
    check(tag, rdata, expect_read(a));
    if (use_hand) check({tag, "_hand"}, rdata, hand);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; idle(2);
      pin = 1'b0; idle(2);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset values
    bus_read(2'd0, "R1_ctrl", 1, 8'hA7);
    bus_read(2'd1, "R1_low",  1, 8'h00);
    bus_read(2'd2, "R1_hbuf", 1, 8'h00);
    bus_read(2'd3, "R1_flag", 1, 8'h00);

    // R2 internal source, bypass, 8-bit: 8 ticks after the 2-cycle hold-off
    bus_write(2'd0, 8'h88);
    bus_write(2'd1, 8'h10);
    idle(10);
    bus_read(2'd1, "R2_count", 1, 8'h18);

    // R5 hold-off: unchanged for two edges, then counting resumes
    bus_write(2'd1, 8'h40);
    bus_read(2'd1, "R5_t0", 1, 8'h40);
    bus_read(2'd1, "R5_t1", 1, 8'h40);
    bus_read(2'd1, "R5_t2", 1, 8'h40);
    bus_read(2'd1, "R5_t3", 1, 8'h41);

    // R4 ratio code 1 -> divide by 4: 20 ticks give 5 counts
    bus_write(2'd0, 8'h81);
    bus_write(2'd1, 8'h00);
    idle(22);
    bus_read(2'd1, "R4_div4", 1, 8'h05);

    // R3 rising edges of the pin
    bus_write(2'd0, 8'hA8);
    bus_write(2'd1, 8'h00);
    pin_pulses(6);
    idle(4);
    bus_read(2'd1, "R3_rise", 1, 8'h06);
    // R3 falling edges
    bus_write(2'd0, 8'hB8);
    bus_write(2'd1, 8'h00);
    pin_pulses(5);
    idle(4);
    bus_read(2'd1, "R3_fall", 1, 8'h05);

    // R6 coherent 16-bit read across the 0x12FF->0x1300 carry
    bus_write(2'd0, 8'hC8);
    bus_write(2'd2, 8'h12);
    bus_write(2'd1, 8'hFA);
    idle(10);
    bus_read(2'd1, "R6_low", 1, 8'h02);
    bus_read(2'd2, "R6_high", 1, 8'h13);

    // R7 buffer write alone does not reach the live high byte
    bus_write(2'd2, 8'h55);
    bus_read(2'd2, "R7_buf", 1, 8'h55);
    bus_read(2'd1, "R7_low", 0, 8'h00);
    bus_read(2'd2, "R7_live_high", 1, 8'h13);

    // R8 8-bit wrap leaves the high byte alone; R9 wrap sets the flag
    bus_write(2'd0, 8'h48);
    bus_write(2'd3, 8'h00);
    bus_write(2'd2, 8'h34);
    bus_write(2'd1, 8'hF0);
    bus_write(2'd0, 8'h88);
    bus_write(2'd2, 8'h77);
    idle(40);
    bus_read(2'd2, "R8_no_latch", 1, 8'h77);
    bus_write(2'd0, 8'h48);
    bus_read(2'd1, "R8_low", 0, 8'h00);
    bus_read(2'd2, "R8_high_kept", 1, 8'h34);
    bus_read(2'd3, "R9_flag_set", 1, 8'h01);

    // R10 writing 1 keeps the flag, writing 0 clears it
    bus_write(2'd3, 8'h01);
    bus_read(2'd3, "R10_write1", 1, 8'h01);
    bus_write(2'd3, 8'hFE);
    bus_read(2'd3, "R10_write0", 1, 8'h00);

    // R11 stopped counter
    bus_write(2'd1, 8'h9C);
    idle(12);
    bus_read(2'd1, "R11_halt", 1, 8'h9C);

    // Random traffic against the reference
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [1:0] a;
      logic [7:0] d;
      pin = ($urandom % 3) == 0 ? ~pin : pin;
      op = $urandom % 10;
      a  = 2'($urandom % 4);
      d  = 8'($urandom);
      if (a == 2'd0 && ($urandom % 2) == 0) d[7] = 1'b1;
      if (op < 4) idle(1);
      else if (op < 7) bus_read(a, "RND_read", 0, 8'h00);
      else bus_write(a, d);
    end
    for (int a = 0; a < 4; a++) bus_read(2'(a), "RND_final", 0, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule